// File: doc/BRIEF.md
# Center-Aligned Complementary Three-Phase PWM Generator

This block drives a three-phase inverter bridge. Each phase has a high-side (top) output and a low-side (bottom) output. Both are placed symmetrically about the middle of a timer period. A built-in up-counter parks at the all-ones value (-1), counts up to `period-2` and then reloads to -1, so one PWM cycle lasts `period` clocks.

Software presents a period, a dead time, a minimum pulse width and one on-time per phase, all in timer ticks, and pulses a commit strobe. The block latches these values into shadow registers. At the next timer reload it converts them into compare values for every phase at once and makes them active together with the new period. On-times shorter than the minimum width are cancelled, and on-times too close to full scale are promoted to a full period. The bottom output is the inverse of a top window that is widened by twice the dead time. A centre marker output is high for half of every cycle, and its rising edge sits at the reload.

Top module: `tri_phase_cpwm`

## Requirements
- R1: After reset every top, bottom and centre output is low. While `en_i` is low the timer is parked at -1 (all ones) and no output changes.
- R2: While enabled, the timer steps from -1 by one each clock up to `P-2` and then returns to -1, so a cycle lasts P clocks (P >= 2). The match uses the active period.
- R3: With effective on-time T, the top leading compare is floor((P-T)/2)-1 and the trailing compare is floor((P+T)/2)-1. The top output goes high on the clock after the timer equals the leading value and low on the clock after it equals the trailing value. Trailing wins when both match.
- R4: A requested on-time below the minimum width M becomes 0. One above P-M becomes P. Below-minimum is tested first.
- R5: For T > 0 the bottom on-time is T+2·dead, replaced by P if that exceeds P-M. For T = 0 it stays 0. The bottom output goes low at its leading match and high at its trailing match, so it is never high while the top output of the same phase is high.
- R6: T = 0 puts both compares on the same tick: the top stays low and the bottom stays high. T = P puts the leading compare at -1 and the trailing compare at P-1, which is never reached: the top stays high and the bottom stays low.
- R7: The centre output is set when the timer equals P-2 and cleared when it equals floor(P/2)-2, so it is high for P/2 samples of each cycle (even P).
- R8: A commit latches all inputs into shadow storage. Active compare values and the active period change only on the clock at which the timer reloads, and all phases and the period change together on that clock.
- R9: A pending commit while `en_i` is low becomes active on the next clock. A commit on the reload clock activates the earlier shadow and leaves the new one pending. Of several commits before a reload, the last one wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| en_i | input | 1 | Timer run enable |
| commit_i | input | 1 | One-clock strobe that latches the shadow values |
| period_i | input | W | Period P in ticks |
| dead_i | input | W | Dead time in ticks |
| minpw_i | input | W | Minimum pulse width M in ticks |
| duty_i | input | N*W | On-time per phase, phase k at bits [k*W +: W] |
| top_o | output | N | High-side outputs, bit k for phase k |
| bot_o | output | N | Low-side outputs, bit k for phase k |
| center_o | output | 1 | Period centre marker |

## Verification
The hardest case to reach from the ports is a commit that lands exactly on the reload clock while an earlier commit is still pending. Both sets of values must then be seen to go active one cycle apart. The bench keeps its own model of the timer and uses it to drive the strobe in the cycle just before the reload edge. Randomised runs then mix period changes, commits mid-cycle and enable drops, while the on-time stimulus covers values at 0, at P, and just inside and outside the minimum-width clamp.

// File: rtl/cpwm_pkg.sv
package cpwm_pkg;

  typedef enum logic [1:0] {
    ACT_HOLD = 2'd0,
    ACT_SET  = 2'd1,
    ACT_CLR  = 2'd2
  } cell_act_e;

  // Trailing match has priority over leading match; inv swaps set and clear.
  function automatic cell_act_e pick_act(logic hit_lead, logic hit_trail, logic inv);
    cell_act_e a;
    if (hit_trail)     a = inv ? ACT_SET : ACT_CLR;
    else if (hit_lead) a = inv ? ACT_CLR : ACT_SET;
    else               a = ACT_HOLD;
    return a;
  endfunction

  function automatic logic apply_act(cell_act_e a, logic cur);
    logic r;
    case (a)
      ACT_SET: r = 1'b1;
      ACT_CLR: r = 1'b0;
      default: r = cur;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/cpwm_timer.sv
module cpwm_timer #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en_i,
  input  logic [W-1:0] per_i,
  output logic [W-1:0] cnt_o,
  output logic         reload_o
);

  localparam logic [W-1:0] PARK = '1;

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;
  logic [W-1:0] match;

  assign match    = per_i - W'(2);
  assign reload_o = en_i && (cnt_q == match);
  assign cnt_o    = cnt_q;

  always_comb begin
    cnt_d = cnt_q;
    if (!en_i)         cnt_d = PARK;
    else if (reload_o) cnt_d = PARK;
    else               cnt_d = cnt_q + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= PARK;
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/cpwm_edge_calc.sv
module cpwm_edge_calc #(
  parameter int W = 16
) (
  input  logic [W-1:0] per_i,
  input  logic [W-1:0] dead_i,
  input  logic [W-1:0] minpw_i,
  input  logic [W-1:0] duty_i,
  output logic [W-1:0] top_lead_o,
  output logic [W-1:0] top_trail_o,
  output logic [W-1:0] bot_lead_o,
  output logic [W-1:0] bot_trail_o
);

  localparam int XW = W + 3;
  typedef logic signed [XW-1:0] ext_t;

  ext_t p, mn, dt, d, mx, t, tw, tb;

  function automatic logic [W-1:0] lead_of(ext_t pp, ext_t on);
    return W'(((pp - on) >>> 1) - ext_t'(1));
  endfunction

  function automatic logic [W-1:0] trail_of(ext_t pp, ext_t on);
    return W'(((pp + on) >>> 1) - ext_t'(1));
  endfunction

  assign p  = $signed({3'b000, per_i});
  assign mn = $signed({3'b000, minpw_i});
  assign dt = $signed({3'b000, dead_i});
  assign d  = $signed({3'b000, duty_i});
  assign mx = p - mn;

  // on-time clamp: cancel short pulses first, then promote near-full ones
  always_comb begin
    if (d < mn)      t = '0;
    else if (d > mx) t = p;
    else             t = d;
  end

  assign tw = t + (dt <<< 1);

  always_comb begin
    if (t == '0)      tb = '0;
    else if (tw > mx) tb = p;
    else              tb = tw;
  end

  assign top_lead_o  = lead_of(p, t);
  assign top_trail_o = trail_of(p, t);
  assign bot_lead_o  = lead_of(p, tb);
  assign bot_trail_o = trail_of(p, tb);

endmodule

// File: rtl/cpwm_out_cell.sv
module cpwm_out_cell
  import cpwm_pkg::*;
#(
  parameter int W      = 16,
  parameter bit INVERT = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en_i,
  input  logic [W-1:0] cnt_i,
  input  logic [W-1:0] lead_i,
  input  logic [W-1:0] trail_i,
  output logic         out_o
);

  logic      out_q;
  logic      out_d;
  cell_act_e act;

  always_comb begin
    act   = pick_act(en_i && (cnt_i == lead_i), en_i && (cnt_i == trail_i), INVERT);
    out_d = apply_act(act, out_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_q <= 1'b0;
    else        out_q <= out_d;
  end

  assign out_o = out_q;

endmodule

// File: rtl/tri_phase_cpwm.sv
module tri_phase_cpwm #(
  parameter int W = 16,
  parameter int N = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           en_i,
  input  logic           commit_i,
  input  logic [W-1:0]   period_i,
  input  logic [W-1:0]   dead_i,
  input  logic [W-1:0]   minpw_i,
  input  logic [N*W-1:0] duty_i,
  output logic [N-1:0]   top_o,
  output logic [N-1:0]   bot_o,
  output logic           center_o
);

  // reset synchroniser: asynchronous assert, synchronous release
  logic [1:0] rsync_q;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_core_n = rsync_q[1];

  // shadow storage
  logic [W-1:0]   sh_per_q,  sh_per_d;
  logic [W-1:0]   sh_dead_q, sh_dead_d;
  logic [W-1:0]   sh_min_q,  sh_min_d;
  logic [N*W-1:0] sh_duty_q, sh_duty_d;
  logic           pend_q,    pend_d;

  logic           reload_w;
  logic           swap;
  logic [W-1:0]   cnt_w;

  assign swap = pend_q && (reload_w || !en_i);

  always_comb begin
    sh_per_d  = sh_per_q;
    sh_dead_d = sh_dead_q;
    sh_min_d  = sh_min_q;
    sh_duty_d = sh_duty_q;
    pend_d    = pend_q;
    if (commit_i) begin
      sh_per_d  = period_i;
      sh_dead_d = dead_i;
      sh_min_d  = minpw_i;
      sh_duty_d = duty_i;
      pend_d    = 1'b1;
    end else if (swap) begin
      pend_d    = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      sh_per_q  <= '0;
      sh_dead_q <= '0;
      sh_min_q  <= '0;
      sh_duty_q <= '0;
      pend_q    <= 1'b0;
    end else begin
      sh_per_q  <= sh_per_d;
      sh_dead_q <= sh_dead_d;
      sh_min_q  <= sh_min_d;
      sh_duty_q <= sh_duty_d;
      pend_q    <= pend_d;
    end
  end

  // compare values computed from shadow storage
  logic [W-1:0] e_tl [N];
  logic [W-1:0] e_tt [N];
  logic [W-1:0] e_bl [N];
  logic [W-1:0] e_bt [N];

  for (genvar k = 0; k < N; k++) begin : g_calc
    cpwm_edge_calc #(.W(W)) i_calc (
      .per_i       (sh_per_q),
      .dead_i      (sh_dead_q),
      .minpw_i     (sh_min_q),
      .duty_i      (sh_duty_q[k*W +: W]),
      .top_lead_o  (e_tl[k]),
      .top_trail_o (e_tt[k]),
      .bot_lead_o  (e_bl[k]),
      .bot_trail_o (e_bt[k])
    );
  end

  // active compare set, switched as a whole on swap
  logic [W-1:0] act_per_q, act_per_d;
  logic [W-1:0] act_tl_q [N];
  logic [W-1:0] act_tt_q [N];
  logic [W-1:0] act_bl_q [N];
  logic [W-1:0] act_bt_q [N];
  logic [W-1:0] act_tl_d [N];
  logic [W-1:0] act_tt_d [N];
  logic [W-1:0] act_bl_d [N];
  logic [W-1:0] act_bt_d [N];

  always_comb begin
    act_per_d = act_per_q;
    for (int k = 0; k < N; k++) begin
      act_tl_d[k] = act_tl_q[k];
      act_tt_d[k] = act_tt_q[k];
      act_bl_d[k] = act_bl_q[k];
      act_bt_d[k] = act_bt_q[k];
    end
    if (swap) begin
      act_per_d = sh_per_q;
      for (int k = 0; k < N; k++) begin
        act_tl_d[k] = e_tl[k];
        act_tt_d[k] = e_tt[k];
        act_bl_d[k] = e_bl[k];
        act_bt_d[k] = e_bt[k];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      act_per_q <= '0;
      for (int k = 0; k < N; k++) begin
        act_tl_q[k] <= '0;
        act_tt_q[k] <= '0;
        act_bl_q[k] <= '0;
        act_bt_q[k] <= '0;
      end
    end else begin
      act_per_q <= act_per_d;
      for (int k = 0; k < N; k++) begin
        act_tl_q[k] <= act_tl_d[k];
        act_tt_q[k] <= act_tt_d[k];
        act_bl_q[k] <= act_bl_d[k];
        act_bt_q[k] <= act_bt_d[k];
      end
    end
  end

  cpwm_timer #(.W(W)) i_timer (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .en_i     (en_i),
    .per_i    (act_per_q),
    .cnt_o    (cnt_w),
    .reload_o (reload_w)
  );

  for (genvar k = 0; k < N; k++) begin : g_phase
    cpwm_out_cell #(.W(W), .INVERT(1'b0)) i_top (
      .clk     (clk),
      .rst_n   (rst_core_n),
      .en_i    (en_i),
      .cnt_i   (cnt_w),
      .lead_i  (act_tl_q[k]),
      .trail_i (act_tt_q[k]),
      .out_o   (top_o[k])
    );
    cpwm_out_cell #(.W(W), .INVERT(1'b1)) i_bot (
      .clk     (clk),
      .rst_n   (rst_core_n),
      .en_i    (en_i),
      .cnt_i   (cnt_w),
      .lead_i  (act_bl_q[k]),
      .trail_i (act_bt_q[k]),
      .out_o   (bot_o[k])
    );
  end

  logic [W-1:0] c_set;
  logic [W-1:0] c_clr;
  assign c_set = act_per_q - W'(2);
  assign c_clr = (act_per_q >> 1) - W'(2);

  cpwm_out_cell #(.W(W), .INVERT(1'b0)) i_center (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .en_i    (en_i),
    .cnt_i   (cnt_w),
    .lead_i  (c_set),
    .trail_i (c_clr),
    .out_o   (center_o)
  );

endmodule

// File: rtl/tri_phase_cpwm_chk.sv
module tri_phase_cpwm_chk #(
  parameter int W = 16,
  parameter int N = 3
) (
  input logic         clk,
  input logic         rst_n,
  input logic         en_i,
  input logic         commit_i,
  input logic [N-1:0] top_o,
  input logic [N-1:0] bot_o,
  input logic         center_o,
  input logic [W-1:0] cnt_i,
  input logic [W-1:0] act_per_i,
  input logic         pend_i,
  input logic         reload_i
);

  // R1: a disabled block freezes every output
  p_idle_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> ($stable(top_o) && $stable(bot_o) && $stable(center_o)));

  // R2: the running timer never passes the active match value
  p_timer_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && (cnt_i != '1)) |-> (cnt_i <= act_per_i - W'(2)));

  // R5: high and low side of a phase are never on together
  p_no_overlap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((top_o & bot_o) == '0));

  // R7: the centre marker rises only after the reload tick
  p_center_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(center_o) |-> ($past(cnt_i) == $past(act_per_i) - W'(2)));

  // R8: the active period changes only at a reload (or while idle) with a pending commit
  p_swap_time_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (act_per_i != $past(act_per_i)) |-> ($past(pend_i) && ($past(reload_i) || !$past(en_i))));

  // R9: an idle block consumes a pending commit on the next clock
  p_idle_swap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_i && !commit_i && !en_i) |=> !pend_i);

endmodule

bind tri_phase_cpwm tri_phase_cpwm_chk #(.W(W), .N(N)) i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .en_i      (en_i),
  .commit_i  (commit_i),
  .top_o     (top_o),
  .bot_o     (bot_o),
  .center_o  (center_o),
  .cnt_i     (cnt_w),
  .act_per_i (act_per_q),
  .pend_i    (pend_q),
  .reload_i  (reload_w)
);

// File: tb/test_tri_phase_cpwm.sv
`timescale 1ns/1ps
module test_tri_phase_cpwm;

  localparam int W    = 16;
  localparam int N    = 3;
  localparam int MASK = 16'hFFFF;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           en_i = 1'b0;
  logic           commit_i = 1'b0;
  logic [W-1:0]   period_i = '0;
  logic [W-1:0]   dead_i = '0;
  logic [W-1:0]   minpw_i = '0;
  logic [N*W-1:0] duty_i = '0;
  logic [N-1:0]   top_o;
  logic [N-1:0]   bot_o;
  logic           center_o;

  always #2 clk = ~clk;

  tri_phase_cpwm #(.W(W), .N(N)) i_tri_phase_cpwm (
    .clk      (clk),
    .rst_n    (rst_n),
    .en_i     (en_i),
    .commit_i (commit_i),
    .period_i (period_i),
    .dead_i   (dead_i),
    .minpw_i  (minpw_i),
    .duty_i   (duty_i),
    .top_o    (top_o),
    .bot_o    (bot_o),
    .center_o (center_o)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit cmp_on = 0;

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int m_timer = MASK;
  bit m_pend = 0;
  int sh_p = 0, sh_d = 0, sh_m = 0;
  int sh_t [N];
  int a_p = 0;
  int a_tl [N], a_tt [N], a_bl [N], a_bt [N];
  bit m_top [N], m_bot [N];
  bit m_cen = 0;

  initial begin
    for (int k = 0; k < N; k++) begin
      sh_t[k] = 0; a_tl[k] = 0; a_tt[k] = 0; a_bl[k] = 0; a_bt[k] = 0;
      m_top[k] = 0; m_bot[k] = 0;
    end
  end

  function automatic void window(input int p, input int d, input int m, input int req,
                                 output int tl, output int tt, output int bl, output int bt);
    int on, onb, hi;
    hi = p - m;
    if (req < m)       on = 0;
    else if (req > hi) on = p;
    else               on = req;
    if (on == 0)              onb = 0;
    else if (on + 2*d > hi)   onb = p;
    else                      onb = on + 2*d;
    tl = ((p - on) / 2 - 1) & MASK;
    tt = ((p + on) / 2 - 1) & MASK;
    bl = ((p - onb) / 2 - 1) & MASK;
    bt = ((p + onb) / 2 - 1) & MASK;
  endfunction

  bit m_rl, m_sw;
  int c_s, c_c;
  always @(posedge clk) begin
    m_rl = en_i && (m_timer == ((a_p - 2) & MASK));
    m_sw = m_pend && (m_rl || !en_i);
    if (en_i) begin
      for (int k = 0; k < N; k++) begin
        if (m_timer == a_tt[k])      m_top[k] = 0;
        else if (m_timer == a_tl[k]) m_top[k] = 1;
        if (m_timer == a_bt[k])      m_bot[k] = 1;
        else if (m_timer == a_bl[k]) m_bot[k] = 0;
      end
      c_s = (a_p - 2) & MASK;
      c_c = (a_p / 2 - 2) & MASK;
      if (m_timer == c_c)      m_cen = 0;
      else if (m_timer == c_s) m_cen = 1;
    end
    if (!en_i || m_rl) m_timer = MASK;
    else               m_timer = (m_timer + 1) & MASK;
    if (m_sw) begin
      a_p = sh_p;
      for (int k = 0; k < N; k++)
        window(sh_p, sh_d, sh_m, sh_t[k], a_tl[k], a_tt[k], a_bl[k], a_bt[k]);
    end
    if (commit_i) begin
      sh_p = int'(period_i); sh_d = int'(dead_i); sh_m = int'(minpw_i);
      for (int k = 0; k < N; k++) sh_t[k] = int'(duty_i[k*W +: W]);
      m_pend = 1;
    end else if (m_sw) begin
      m_pend = 0;
    end
  end

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (cmp_on) begin
      for (int k = 0; k < N; k++) begin
        chk(top_o[k] == m_top[k], "R3 top vs model", int'(top_o[k]), int'(m_top[k]));
        chk(bot_o[k] == m_bot[k], "R5 bottom vs model", int'(bot_o[k]), int'(m_bot[k]));
      end
      chk(center_o == m_cen, "R7 centre vs model", int'(center_o), int'(m_cen));
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic set_vals(int p, int d, int m, int t0, int t1, int t2);
    period_i = W'(p); dead_i = W'(d); minpw_i = W'(m);
    duty_i[0*W +: W] = W'(t0);
    duty_i[1*W +: W] = W'(t1);
    duty_i[2*W +: W] = W'(t2);
  endtask

  task automatic commit_now(int p, int d, int m, int t0, int t1, int t2);
    @(negedge clk);
    set_vals(p, d, m, t0, t1, t2);
    commit_i = 1'b1;
    @(negedge clk);
    commit_i = 1'b0;
  endtask

  task automatic count_win(int p, int et0, int et1, int et2, int eb0, int eb1, int eb2,
                           int ec, string rt, string rb);
    int ct [N];
    int cb [N];
    int cc;
    int et [N];
    int eb [N];
    et[0] = et0; et[1] = et1; et[2] = et2;
    eb[0] = eb0; eb[1] = eb1; eb[2] = eb2;
    cc = 0;
    for (int k = 0; k < N; k++) begin ct[k] = 0; cb[k] = 0; end
    for (int i = 0; i < p; i++) begin
      @(negedge clk);
      for (int k = 0; k < N; k++) begin
        ct[k] += int'(top_o[k]);
        cb[k] += int'(bot_o[k]);
      end
      cc += int'(center_o);
    end
    for (int k = 0; k < N; k++) begin
      chk(ct[k] == et[k], rt, ct[k], et[k]);
      chk(cb[k] == eb[k], rb, cb[k], eb[k]);
    end
    chk(cc == ec, "R7 centre high count", cc, ec);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  // ---------------- main sequence ----------------
  bit [31:0] lcg = 32'h1234_5678;
  function automatic int rnd(int n);
    lcg = lcg * 32'd1103515245 + 32'd12345;
    return int'(lcg[30:16]) % n;
  endfunction

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1: reset state
    chk(top_o == '0, "R1 top after reset", int'(top_o), 0);
    chk(bot_o == '0, "R1 bottom after reset", int'(bot_o), 0);
    chk(center_o == 1'b0, "R1 centre after reset", int'(center_o), 0);
    cmp_on = 1;

    // R9: commit while idle; R1: outputs stay put while disabled
    commit_now(8, 1, 0, 4, 1, 0);
    repeat (3) @(negedge clk);
    chk(top_o == '0 && bot_o == '0, "R1 idle hold", int'({top_o, bot_o}), 0);
    en_i = 1'b1;
    repeat (20) @(negedge clk);
    // R3/R5: 50%, 12.5%, 0% with P=8, dead=1
    count_win(8, 4, 1, 0, 2, 5, 8, 4, "R3 top high count", "R5 bottom high count");

    // R6: full-scale and near full-scale
    commit_now(8, 1, 0, 8, 7, 2);
    repeat (20) @(negedge clk);
    count_win(8, 8, 7, 2, 0, 0, 4, 4, "R6 top high count", "R6 bottom high count");

    // R4: minimum-pulse cancellation and promotion
    commit_now(20, 2, 3, 2, 18, 10);
    repeat (44) @(negedge clk);
    count_win(20, 0, 20, 10, 20, 0, 6, 10, "R4 top high count", "R4 bottom high count");

    // R8: new period and duties, committed mid-cycle, take effect together
    repeat (7) @(negedge clk);
    commit_now(12, 1, 1, 6, 3, 12);
    repeat (28) @(negedge clk);
    count_win(12, 6, 3, 12, 4, 7, 0, 6, "R8 top after switch", "R8 bottom after switch");

    // R9: pending commit, then a second commit placed on the reload clock
    commit_now(10, 0, 0, 4, 2, 8);
    while (m_timer != ((a_p - 2) & MASK)) @(negedge clk);
    set_vals(16, 1, 2, 8, 1, 15);
    commit_i = 1'b1;
    @(negedge clk);
    commit_i = 1'b0;
    chk(m_pend == 1'b1, "R9 second commit left pending in model", int'(m_pend), 1);
    repeat (40) @(negedge clk);
    // Ton 1 -> cancelled (M=2); Ton 15 > 14 -> 16; Ton 8 -> bottom 10
    count_win(16, 8, 0, 16, 6, 16, 0, 8, "R9 top last commit", "R9 bottom last commit");

    // R1: disable mid-run, then resume
    repeat (5) @(negedge clk);
    en_i = 1'b0;
    repeat (10) @(negedge clk);
    en_i = 1'b1;

    // randomised runs, model-compared every clock (R2, R8, R9)
    for (int it = 0; it < 60; it++) begin
      int p;
      p = 2 + rnd(30);
      commit_now(p, rnd(4), rnd(3), rnd(p + 3), rnd(p + 3), rnd(p + 3));
      if (rnd(4) == 0) commit_now(p, rnd(4), rnd(3), rnd(p + 3), rnd(p + 3), rnd(p + 3));
      repeat (rnd(3 * p + 4)) @(negedge clk);
      if (rnd(8) == 0) begin
        en_i = 1'b0;
        repeat (1 + rnd(5)) @(negedge clk);
        en_i = 1'b1;
      end
    end
    repeat (80) @(negedge clk);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule